// File: doc/BRIEF.md
# Shared Memory Bus Ownership Arbiter

This block decides which of four masters owns a shared external memory bus: an outside or PCI-side requester that wants the bus handed over, the memory refresh engine, the DMA controller and the CPU. Ownership changes only when the current owner reaches a transfer boundary. At that point the block grants the bus to the highest-ranked active candidate. The grant is a registered one-hot vector. A registered acknowledge tells the outside requester that the bus has been handed to it.

Two configuration bits are captured from a write strobe and both clear on reset. The first lets outside requests be accepted. The second turns on DMA burst priority: while a DMA burst owns the bus, the bus is not handed outside and refresh is not granted until the burst's final transfer. A startup-mode input makes outside requests acceptable whatever the enable bit holds. A refresh request that cannot be served at once is latched and kept until the bus is granted to refresh.

Top module: `bus_owner_arb`

## Requirements
- R1: After reset the grant is CPU-only (`grant` = 4'b1000; bit 0 outside, bit 1 refresh, bit 2 DMA, bit 3 CPU), `ext_ack` is 0, and both configuration bits read as 0.
- R2: From the first clock after reset, exactly one bit of `grant` is set on every cycle.
- R3: `grant` changes only at a boundary: `xfer_done` high, or the outside owner has dropped `ext_req`, or the CPU owns the bus and `cpu_req` is low.
- R4: At a boundary the bus goes to the first active candidate in this order: outside requester, pending refresh, DMA, CPU.
- R5: While the enable bit is 0 and `slave_mode` is 0, `ext_req` is ignored and the outside requester is never newly granted.
- R6: While `slave_mode` is 1, `ext_req` is accepted even when the enable bit is 0.
- R7: With burst priority set and DMA owning the bus, a boundary that has `xfer_done` high and `burst_last` low grants neither the outside requester nor refresh.
- R8: A one-cycle `ref_req` pulse stays pending until refresh is granted. Refresh is then granted at the first boundary that has no accepted, unlocked outside request.
- R9: When no other candidate is active at a boundary, the CPU gets the grant.
- R10: `ext_ack` equals `grant[0]` on every cycle. It goes low on the clock edge after the cycle in which the outside owner drops `ext_req`.
- R11: On a cycle with `cfg_we` high, the enable and burst priority bits take the values of `cfg_ext_en` and `cfg_burst_pri`. They affect arbitration from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req | input | 1 | Outside / PCI-side bus request (level) |
| ref_req | input | 1 | Refresh request (pulse or level) |
| dma_req | input | 1 | DMA controller request (level) |
| cpu_req | input | 1 | CPU has a transfer in progress or waiting |
| xfer_done | input | 1 | Current owner finishes a transfer this cycle |
| burst_last | input | 1 | The finishing DMA transfer ends its burst |
| slave_mode | input | 1 | Startup mode that forces outside requests to be accepted |
| cfg_we | input | 1 | Write strobe for the configuration bits |
| cfg_ext_en | input | 1 | Enable value for outside requests |
| cfg_burst_pri | input | 1 | DMA burst priority value |
| grant | output | 4 | Registered one-hot owner |
| ext_ack | output | 1 | Registered bus-released acknowledge to the outside requester |

## Verification
The critical overlap is a refresh pulse and an outside request arriving at the same boundary as the last beat of a locked DMA burst. In that cycle the burst lock, the refresh pending latch and the fixed ranking all act at once. The bench provokes this directly: it raises `ext_req` and pulses `ref_req` while a burst runs, closes one beat without `burst_last`, and then closes one with it. It expects DMA to keep the bus on the first beat, the outside requester to win on the second, and refresh to follow when `ext_req` drops. A behavioural model also compares `grant` and `ext_ack` on every clock, both through these directed sequences and through long random runs.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_REQ = 4;
  localparam int IDX_EXT = 0;
  localparam int IDX_REF = 1;
  localparam int IDX_DMA = 2;
  localparam int IDX_CPU = 3;
  typedef logic [NUM_REQ-1:0] grant_t;
  localparam grant_t GRANT_RESET = grant_t'(1) << IDX_CPU;
endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs (
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  logic ext_en_in,
  input  logic burst_pri_in,
  output logic ext_en,
  output logic burst_pri
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_en    <= 1'b0;
      burst_pri <= 1'b0;
    end else if (we) begin
      ext_en    <= ext_en_in;
      burst_pri <= burst_pri_in;
    end
  end
endmodule

// File: rtl/arb_ref_pend.sv
module arb_ref_pend (
  input  logic clk,
  input  logic rst,
  input  logic req_in,
  input  logic served,
  output logic active
);
  logic pend_q;

  assign active = pend_q | req_in;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= served ? 1'b0 : active;
  end

  // R8: a raised request is held until it is served
  assert_pend_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (active && !served) |=> active);
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N-1:0] seen;

  generate
    for (genvar i = 0; i < N; i++) begin : g_rank
      if (i == 0) begin : g_top
        assign seen[i] = req[i];
        assign gnt[i]  = req[i];
      end else begin : g_rest
        assign seen[i] = seen[i-1] | req[i];
        assign gnt[i]  = req[i] & ~seen[i-1];
      end
    end
  endgenerate
endmodule

// File: rtl/bus_owner_arb.sv
module bus_owner_arb
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_req,
  input  logic       ref_req,
  input  logic       dma_req,
  input  logic       cpu_req,
  input  logic       xfer_done,
  input  logic       burst_last,
  input  logic       slave_mode,
  input  logic       cfg_we,
  input  logic       cfg_ext_en,
  input  logic       cfg_burst_pri,
  output logic [3:0] grant,
  output logic       ext_ack
);
  logic   ext_en_q, burst_pri_q;
  logic   ref_active, ref_served;
  logic   boundary, locked, ext_ok;
  grant_t grant_q, cand, pick, grant_d;
  logic   ack_q;

  arb_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we),
    .ext_en_in(cfg_ext_en), .burst_pri_in(cfg_burst_pri),
    .ext_en(ext_en_q), .burst_pri(burst_pri_q)
  );

  arb_ref_pend u_ref (
    .clk(clk), .rst(rst), .req_in(ref_req),
    .served(ref_served), .active(ref_active)
  );

  assign boundary = xfer_done
                  | (grant_q[IDX_EXT] & ~ext_req)
                  | (grant_q[IDX_CPU] & ~cpu_req);
  assign locked   = burst_pri_q & grant_q[IDX_DMA] & ~burst_last;
  assign ext_ok   = ext_req & (ext_en_q | slave_mode);

  always_comb begin
    cand          = '0;
    cand[IDX_EXT] = ext_ok & ~locked;
    cand[IDX_REF] = ref_active & ~locked;
    cand[IDX_DMA] = dma_req;
    cand[IDX_CPU] = 1'b1;
  end

  arb_pick #(.N(NUM_REQ)) u_pick (.req(cand), .gnt(pick));

  assign grant_d    = boundary ? pick : grant_q;
  assign ref_served = boundary & pick[IDX_REF];

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= GRANT_RESET;
      ack_q   <= 1'b0;
    end else begin
      grant_q <= grant_d;
      ack_q   <= grant_d[IDX_EXT];
    end
  end

  assign grant   = grant_q;
  assign ext_ack = ack_q;

  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(grant) == 1);

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!xfer_done && !(grant[IDX_EXT] && !ext_req) && !(grant[IDX_CPU] && !cpu_req))
      |=> $stable(grant));

  assert_ignore_R5: assert property (@(posedge clk) disable iff (rst)
    (!ext_en_q && !slave_mode && !grant[IDX_EXT]) |=> !grant[IDX_EXT]);

  assert_lock_R7: assert property (@(posedge clk) disable iff (rst)
    (burst_pri_q && grant[IDX_DMA] && xfer_done && !burst_last)
      |=> (!grant[IDX_EXT] && !grant[IDX_REF]));

  assert_ack_match_R10: assert property (@(posedge clk) disable iff (rst)
    ext_ack == grant[IDX_EXT]);

  assert_ack_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (grant[IDX_EXT] && !ext_req) |=> !ext_ack);
endmodule

// File: tb/tb_bus_owner_arb.sv
module tb_bus_owner_arb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_req = 0, ref_req = 0, dma_req = 0, cpu_req = 0;
  logic xfer_done = 0, burst_last = 0, slave_mode = 0;
  logic cfg_we = 0, cfg_ext_en = 0, cfg_burst_pri = 0;
  logic [3:0] grant;
  logic ext_ack;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  int m_own;
  bit m_pend, m_en, m_bp, m_ack;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_owner_arb dut (
    .clk(clk), .rst(rst), .ext_req(ext_req), .ref_req(ref_req),
    .dma_req(dma_req), .cpu_req(cpu_req), .xfer_done(xfer_done),
    .burst_last(burst_last), .slave_mode(slave_mode), .cfg_we(cfg_we),
    .cfg_ext_en(cfg_ext_en), .cfg_burst_pri(cfg_burst_pri),
    .grant(grant), .ext_ack(ext_ack)
  );

  // Behavioural reference: owner as an integer 0..3 (outside, refresh, DMA, CPU)
  always @(posedge clk) begin
    bit refeff, bnd, lock, extok;
    int nown;
    if (rst) begin
      m_own = 3; m_pend = 0; m_en = 0; m_bp = 0; m_ack = 0;
    end else begin
      refeff = m_pend | ref_req;
      bnd    = xfer_done | (m_own == 0 && !ext_req) | (m_own == 3 && !cpu_req);
      lock   = m_bp && m_own == 2 && !burst_last;
      extok  = ext_req && (m_en || slave_mode);
      nown   = m_own;
      if (bnd) begin
        if (extok && !lock)       nown = 0;
        else if (refeff && !lock) nown = 1;
        else if (dma_req)         nown = 2;
        else                      nown = 3;
      end
      m_pend = (bnd && nown == 1) ? 1'b0 : refeff;
      if (cfg_we) begin
        m_en = cfg_ext_en;
        m_bp = cfg_burst_pri;
      end
      m_own = nown;
      m_ack = (nown == 0);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    chk(grant == (4'b1 << m_own), "R4 model grant", grant, 4'b1 << m_own);
    chk(ext_ack == m_ack, "R10 model ack", ext_ack, m_ack);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(); cyc();
    chk(grant == 4'b1000, "R1 reset grant", grant, 4'b1000);
    chk(ext_ack == 0, "R1 reset ack", ext_ack, 0);
    rst = 0;

    // R5 / R1: enable cleared at reset, outside request ignored
    ext_req = 1; cyc(); cyc();
    chk(grant == 4'b1000, "R5 ignored ext", grant, 4'b1000);
    ext_req = 0;

    // R11: enable written, then outside request granted
    cfg_we = 1; cfg_ext_en = 1; cyc();
    cfg_we = 0; ext_req = 1; cyc();
    chk(grant == 4'b0001, "R11 ext granted after write", grant, 4'b0001);
    chk(ext_ack == 1, "R10 ack high", ext_ack, 1);
    ext_req = 0; cyc();
    chk(ext_ack == 0, "R10 ack drops", ext_ack, 0);
    chk(grant == 4'b1000, "R9 cpu default", grant, 4'b1000);

    // R4 ordering with everything active
    ext_req = 1; dma_req = 1; ref_req = 1; cyc();
    chk(grant == 4'b0001, "R4 ext first", grant, 4'b0001);
    ref_req = 0; cyc();
    chk(grant == 4'b0001, "R3 hold ext", grant, 4'b0001);
    ext_req = 0; cyc();
    chk(grant == 4'b0010, "R4 refresh second", grant, 4'b0010);
    cyc();
    chk(grant == 4'b0010, "R3 hold refresh", grant, 4'b0010);
    xfer_done = 1; cyc();
    chk(grant == 4'b0100, "R4 dma third", grant, 4'b0100);
    dma_req = 0; cyc();
    chk(grant == 4'b1000, "R9 cpu last", grant, 4'b1000);
    xfer_done = 0;

    // R8: refresh pulse during a DMA transfer stays pending
    dma_req = 1; cyc();
    ref_req = 1; cyc();
    ref_req = 0; cyc(); cyc();
    chk(grant == 4'b0100, "R3 dma held", grant, 4'b0100);
    xfer_done = 1; cyc();
    chk(grant == 4'b0010, "R8 pending refresh", grant, 4'b0010);
    dma_req = 0; cyc();
    xfer_done = 0;

    // R7: burst lock, with outside and refresh arriving during the burst
    cfg_we = 1; cfg_ext_en = 1; cfg_burst_pri = 1; cyc();
    cfg_we = 0; dma_req = 1; cyc();
    ext_req = 1; ref_req = 1; cyc();
    ref_req = 0; xfer_done = 1; burst_last = 0; cyc();
    chk(grant == 4'b0100, "R7 lock keeps dma", grant, 4'b0100);
    burst_last = 1; cyc();
    chk(grant == 4'b0001, "R7 release at burst end", grant, 4'b0001);
    xfer_done = 0; burst_last = 0; dma_req = 0; ext_req = 0; cyc();
    chk(grant == 4'b0010, "R8 refresh after lock", grant, 4'b0010);
    xfer_done = 1; cyc();
    xfer_done = 0;

    // R6: startup mode overrides cleared enable
    cfg_we = 1; cfg_ext_en = 0; cfg_burst_pri = 0; cyc();
    cfg_we = 0; ext_req = 1; cyc();
    chk(grant == 4'b1000, "R5 ext ignored again", grant, 4'b1000);
    slave_mode = 1; cyc();
    chk(grant == 4'b0001, "R6 startup accepts ext", grant, 4'b0001);
    ext_req = 0; slave_mode = 0; cyc();

    // Random traffic checked against the model (R2, R3, R4, R7, R8)
    for (int i = 0; i < 4000; i++) begin
      ext_req       = ($urandom % 3) == 0;
      ref_req       = ($urandom % 8) == 0;
      dma_req       = ($urandom % 2) == 0;
      cpu_req       = ($urandom % 2) == 0;
      xfer_done     = ($urandom % 3) == 0;
      burst_last    = ($urandom % 3) == 0;
      slave_mode    = ($urandom % 16) == 0;
      cfg_we        = ($urandom % 20) == 0;
      cfg_ext_en    = $urandom % 2;
      cfg_burst_pri = $urandom % 2;
      cyc();
      chk($countones(grant) == 1, "R2 one-hot", grant, 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule